// File: doc/BRIEF.md
# Serial Register Slave for a Seconds-Counter Clock

This block is the two-wire serial slave that gives a host access to the ten byte-wide registers of a binary seconds clock. It watches the clock and data lines with the system clock, detects START and STOP conditions and matches its 7-bit device address. In a write transfer, the first data byte loads the register pointer and the following bytes are stored. A read transfer returns bytes from the current pointer. The pointer advances after every byte and returns to zero after the last register.

The 32-bit time value is owned by a neighbouring counter. This block keeps a shadow copy of it, taken at every START, at every STOP and whenever the pointer wraps to zero, so that a multi-byte read returns one consistent value while counting goes on. Writes to the counter-owned registers (time and watchdog/alarm) are passed out as a strobe with address and data. Reads of those registers are also reported as a strobe, so the watchdog can reload. The control, status and charger-select registers are held here.

Register layout: bytes 0–3 hold the time, least significant byte at 0. Bytes 4–6 hold the watchdog/alarm counter, least significant at 4. Byte 7 is control, byte 8 is status and byte 9 is charger select.

Top module: `rtc_i2c_regif`

## Requirements
- R1: The slave acknowledges only the address byte 1101000 followed by the direction bit (0 write, 1 read); any other address is not acknowledged and the slave stays silent until the next START.
- R2: In a write, the first data byte sets the pointer; each later byte is acknowledged, stored at the pointer (control at 7, status at 8, charger at 9), and the pointer then advances by one.
- R3: A read without a preceding pointer byte starts at the pointer left by the previous transfer.
- R4: A read returns one byte per master acknowledge and stops after a not-acknowledge, with SDA released before the master issues STOP.
- R5: After register 9 the pointer wraps to 0, in both reads and writes.
- R6: Time bytes 0–3 are read from a shadow copy of the live time, loaded on START, on STOP and when the pointer wraps to 0; a live change in the middle of a read does not reach the later bytes of that read.
- R7: Every write to a time byte (0–3) gives a one-cycle pulse on `sqw_sync_o`; writes to other registers do not.
- R8: `chg_en_o` is 1 only when the charger register reads 1010 in bits 7:4, 01 or 10 in bits 3:2 and a nonzero value in bits 1:0.
- R9: Status bit 7 (oscillator stopped) and bit 0 (alarm) are set by `osc_stop_i` and `alarm_i`. Writing 0 to a bit clears it and writing 1 leaves it unchanged. Bits 6–1 read as 0.
- R10: While `inhibit_i` is 1, the address is not acknowledged and no register is written.
- R11: After reset the control register is 06h, the charger register is 00h, status reads 80h and SDA is released.
- R12: A pointer byte of 10 or more selects register 0.
- R13: Registers 4–6 return the live watchdog/alarm byte at the moment the byte is loaded for sending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| inhibit_i | input | 1 | Access inhibit while the chip reset is active |
| time_live_i | input | 32 | Live seconds count |
| wdog_live_i | input | 24 | Live watchdog/alarm count |
| osc_stop_i | input | 1 | Sets the oscillator-stopped flag |
| alarm_i | input | 1 | Sets the alarm flag |
| wr_stb_o | output | 1 | One-cycle write strobe for any stored byte |
| wr_addr_o | output | 4 | Register written |
| wr_data_o | output | 8 | Byte written |
| rd_stb_o | output | 1 | One-cycle strobe when a byte is loaded for sending |
| rd_addr_o | output | 4 | Register being read |
| sqw_sync_o | output | 1 | Square-wave phase reset pulse |
| ctrl_o | output | 8 | Control register |
| chg_en_o | output | 1 | Charger enabled |
| chg_diode_o | output | 1 | Charger diode selected |
| chg_res_o | output | 2 | Charger resistor code, 0 when disabled |

## Verification
A pointer wrap and a shadow reload happen in the same cycle: loading register 9 for sending also takes a fresh copy of the time. The bench provokes this by changing the live time in the middle of a long read, after the time bytes and before the wrap. The bytes 1–3 sent after the change must still carry the old value, and byte 0 sent after the wrap must carry the new one. A second overlap is between a flag being set and a host write to status. The bench pulses the alarm input and then writes 1s to status. It judges the result by reading the flag back, which must still be set.

// File: rtl/rtc_i2c_regif.sv
module rtc_i2c_regif #(
  parameter logic [6:0] DEV_ADDR = 7'b1101000,
  parameter int NREG = 10,
  localparam int PW = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe_o,
  input  logic          inhibit_i,
  input  logic [31:0]   time_live_i,
  input  logic [23:0]   wdog_live_i,
  input  logic          osc_stop_i,
  input  logic          alarm_i,
  output logic          wr_stb_o,
  output logic [PW-1:0] wr_addr_o,
  output logic [7:0]    wr_data_o,
  output logic          rd_stb_o,
  output logic [PW-1:0] rd_addr_o,
  output logic          sqw_sync_o,
  output logic [7:0]    ctrl_o,
  output logic          chg_en_o,
  output logic          chg_diode_o,
  output logic [1:0]    chg_res_o
);
  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_RACK} state_t;

  state_t        st;
  logic [2:0]    scl_q, sda_q;
  logic          scl_s, scl_p, sda_s, sda_p;
  logic          start_det, stop_det, scl_rise, scl_fall;
  logic [7:0]    sh, tx, chg, rd_byte;
  logic [3:0]    cnt;
  logic [PW-1:0] ptr, nxt_ptr;
  logic          wrap, is_addr, got_ptr, rw, mack, osf, af;
  logic [31:0]   shadow;

  assign scl_s = scl_q[1];
  assign scl_p = scl_q[2];
  assign sda_s = sda_q[1];
  assign sda_p = sda_q[2];
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign wrap      = (ptr == PW'(NREG - 1));
  assign nxt_ptr   = wrap ? '0 : ptr + 1'b1;

  assign chg_en_o    = (chg[7:4] == 4'b1010) && (chg[3:2] == 2'b01 || chg[3:2] == 2'b10)
                       && (chg[1:0] != 2'b00);
  assign chg_diode_o = chg_en_o & (chg[3:2] == 2'b10);
  assign chg_res_o   = chg_en_o ? chg[1:0] : 2'b00;

  always_comb begin
    case (ptr)
      4'd0:    rd_byte = shadow[7:0];
      4'd1:    rd_byte = shadow[15:8];
      4'd2:    rd_byte = shadow[23:16];
      4'd3:    rd_byte = shadow[31:24];
      4'd4:    rd_byte = wdog_live_i[7:0];
      4'd5:    rd_byte = wdog_live_i[15:8];
      4'd6:    rd_byte = wdog_live_i[23:16];
      4'd7:    rd_byte = ctrl_o;
      4'd8:    rd_byte = {osf, 6'b0, af};
      4'd9:    rd_byte = chg;
      default: rd_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osf <= 1'b1;
      af  <= 1'b0;
    end else begin
      osf <= osc_stop_i | (osf & ~(wr_stb_o && wr_addr_o == PW'(8) && !wr_data_o[7]));
      af  <= alarm_i    | (af  & ~(wr_stb_o && wr_addr_o == PW'(8) && !wr_data_o[0]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; sh <= '0; tx <= '0; cnt <= '0; ptr <= '0;
      is_addr <= 1'b0; got_ptr <= 1'b0; rw <= 1'b0; mack <= 1'b0;
      sda_oe_o <= 1'b0; shadow <= '0; ctrl_o <= 8'h06; chg <= 8'h00;
      wr_stb_o <= 1'b0; wr_addr_o <= '0; wr_data_o <= '0;
      rd_stb_o <= 1'b0; rd_addr_o <= '0; sqw_sync_o <= 1'b0;
    end else begin
      wr_stb_o <= 1'b0;
      rd_stb_o <= 1'b0;
      sqw_sync_o <= 1'b0;
      if (start_det) begin
        st <= S_RX; is_addr <= 1'b1; got_ptr <= 1'b0; cnt <= '0;
        sda_oe_o <= 1'b0; shadow <= time_live_i;
      end else if (stop_det) begin
        st <= S_IDLE; sda_oe_o <= 1'b0; shadow <= time_live_i;
      end else begin
        case (st)
          S_RX: begin
            if (scl_rise) begin
              sh <= {sh[6:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == 4'd8) begin
              cnt <= '0;
              if (inhibit_i) begin
                st <= S_IDLE;
              end else if (is_addr) begin
                if (sh[7:1] == DEV_ADDR) begin
                  rw <= sh[0]; is_addr <= 1'b0; sda_oe_o <= 1'b1; st <= S_ACK;
                end else begin
                  st <= S_IDLE;
                end
              end else if (!got_ptr) begin
                got_ptr <= 1'b1;
                ptr <= (sh < 8'(NREG)) ? sh[PW-1:0] : '0;
                sda_oe_o <= 1'b1; st <= S_ACK;
              end else begin
                wr_stb_o <= 1'b1; wr_addr_o <= ptr; wr_data_o <= sh;
                sqw_sync_o <= (ptr < PW'(4));
                if (ptr == PW'(7)) ctrl_o <= sh;
                if (ptr == PW'(9)) chg <= sh;
                ptr <= nxt_ptr;
                if (wrap) shadow <= time_live_i;
                sda_oe_o <= 1'b1; st <= S_ACK;
              end
            end
          end
          S_ACK: if (scl_fall) begin
            cnt <= '0;
            if (rw) begin
              tx <= rd_byte; sda_oe_o <= ~rd_byte[7];
              rd_stb_o <= 1'b1; rd_addr_o <= ptr; ptr <= nxt_ptr;
              if (wrap) shadow <= time_live_i;
              st <= S_TX;
            end else begin
              sda_oe_o <= 1'b0; st <= S_RX;
            end
          end
          S_TX: if (scl_fall) begin
            if (cnt == 4'd7) begin
              sda_oe_o <= 1'b0; st <= S_RACK;
            end else begin
              tx <= {tx[6:0], 1'b0}; sda_oe_o <= ~tx[6]; cnt <= cnt + 1'b1;
            end
          end
          S_RACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              cnt <= '0;
              if (mack) begin
                tx <= rd_byte; sda_oe_o <= ~rd_byte[7];
                rd_stb_o <= 1'b1; rd_addr_o <= ptr; ptr <= nxt_ptr;
                if (wrap) shadow <= time_live_i;
                st <= S_TX;
              end else begin
                st <= S_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/rtc_i2c_regif_chk.sv
module rtc_i2c_regif_chk #(
  parameter int NREG = 10
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    inhibit_i,
  input logic                    alarm_i,
  input logic                    wr_stb_o,
  input logic [$clog2(NREG)-1:0] wr_addr_o,
  input logic                    sqw_sync_o,
  input logic                    sda_oe_o,
  input logic [$clog2(NREG)-1:0] ptr,
  input logic                    af,
  input logic                    stop_det
);
  p_ptr_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ptr < ($clog2(NREG))'(NREG));

  p_no_write_inhibit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(inhibit_i) |-> !wr_stb_o);

  p_alarm_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(alarm_i) && !$past(af)) |-> !af);

  p_release_after_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stop_det) |-> !sda_oe_o);

  p_sqw_time_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sqw_sync_o |-> (wr_stb_o && wr_addr_o < 4));
endmodule

bind rtc_i2c_regif rtc_i2c_regif_chk #(.NREG(NREG)) u_chk (.*);

// File: tb/test_rtc_i2c_regif.sv
module test_rtc_i2c_regif;
  localparam int Q = 10;
  localparam logic [7:0] AW = 8'hD0;
  localparam logic [7:0] AR = 8'hD1;
  localparam logic [8:0] CHG_VEC [8] = '{
    {8'hA5, 1'b1}, {8'hA6, 1'b1}, {8'hAB, 1'b1}, {8'hA4, 1'b0},
    {8'hA1, 1'b0}, {8'hAD, 1'b0}, {8'h55, 1'b0}, {8'hB9, 1'b0}};

  logic clk = 0, rst_n = 0;
  logic scl = 1, sda_m = 1, sda_line;
  logic inhibit = 0, osc_stop = 0, alarm = 0;
  logic [31:0] tlive = 32'h0;
  logic [23:0] wlive = 24'h665544;
  logic sda_oe, wr_stb, rd_stb, sqw, chg_en, chg_diode;
  logic [3:0] wr_addr, rd_addr;
  logic [7:0] wr_data, ctrl;
  logic [1:0] chg_res;
  int n_chk = 0, n_bad = 0, sqw_cnt = 0;
  bit done = 0;

  always #5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  rtc_i2c_regif i_rtc_i2c_regif (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .inhibit_i(inhibit), .time_live_i(tlive), .wdog_live_i(wlive),
    .osc_stop_i(osc_stop), .alarm_i(alarm), .wr_stb_o(wr_stb), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .rd_stb_o(rd_stb), .rd_addr_o(rd_addr), .sqw_sync_o(sqw),
    .ctrl_o(ctrl), .chg_en_o(chg_en), .chg_diode_o(chg_diode), .chg_res_o(chg_res));

  always @(negedge clk) if (sqw) sqw_cnt++;

  task automatic w(input int n); repeat (n) @(negedge clk); endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic i2c_start;
    sda_m = 1; w(Q); scl = 1; w(Q); sda_m = 0; w(Q); scl = 0; w(Q);
  endtask

  task automatic i2c_stop;
    sda_m = 0; w(Q); scl = 1; w(Q); sda_m = 1; w(Q);
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; w(Q); scl = 1; w(Q); scl = 0; w(Q);
    end
    sda_m = 1; w(Q); scl = 1; w(Q); ack = ~sda_line; scl = 0; w(Q);
  endtask

  task automatic get_byte(input logic ack, output logic [7:0] b);
    sda_m = 1;
    for (int i = 0; i < 8; i++) begin
      scl = 1; w(Q); b = {b[6:0], sda_line}; scl = 0; w(Q);
    end
    sda_m = ~ack; w(Q); scl = 1; w(Q); scl = 0; w(Q); sda_m = 1;
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    logic k;
    i2c_start; put_byte(AW, k); put_byte(a, k); put_byte(d, k); i2c_stop;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
    logic k;
    i2c_start; put_byte(AW, k); put_byte(a, k);
    i2c_start; put_byte(AR, k); get_byte(1'b0, d); i2c_stop;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic k;
    logic [7:0] d;
    int base;
    w(4); rst_n = 1; w(4);
    check("R11 ctrl", ctrl, 8'h06);
    check("R11 chg_en", chg_en, 1'b0);
    check("R11 sda", sda_oe, 1'b0);
    rd_reg(8'd8, d); check("R11 status", d, 8'h80);
    rd_reg(8'd9, d); check("R11 charger", d, 8'h00);

    // R8: table of charger codes walked by one loop
    foreach (CHG_VEC[i]) begin
      wr_reg(8'd9, CHG_VEC[i][8:1]); w(2);
      check("R8 chg_en", chg_en, CHG_VEC[i][0]);
    end

    // R1: address match
    i2c_start; put_byte(8'hA0, k); i2c_stop; check("R1 foreign nack", k, 1'b0);
    i2c_start; put_byte(AW, k); i2c_stop; check("R1 own ack", k, 1'b1);

    // R10: inhibit
    inhibit = 1;
    i2c_start; put_byte(AW, k); i2c_stop; check("R10 inhibit nack", k, 1'b0);
    wr_reg(8'd7, 8'hEE); check("R10 no write", ctrl, 8'h06);
    inhibit = 0;

    // R2 + R9: pointer 7, then control, then status (clears oscillator flag)
    i2c_start; put_byte(AW, k); put_byte(8'd7, k); put_byte(8'h5A, k); put_byte(8'h7F, k); i2c_stop;
    check("R2 ctrl", ctrl, 8'h5A);
    rd_reg(8'd8, d); check("R2 R9 status cleared via increment", d, 8'h00);
    alarm = 1; w(1); alarm = 0; w(2);
    rd_reg(8'd8, d); check("R9 alarm set", d, 8'h01);
    wr_reg(8'd8, 8'hFF); rd_reg(8'd8, d); check("R9 write 1 keeps", d, 8'h01);
    wr_reg(8'd8, 8'h00); rd_reg(8'd8, d); check("R9 write 0 clears", d, 8'h00);
    osc_stop = 1; w(1); osc_stop = 0; w(2);
    rd_reg(8'd8, d); check("R9 osc flag", d, 8'h80);

    // R7: square-wave sync on time writes only
    base = sqw_cnt;
    i2c_start; put_byte(AW, k); put_byte(8'd0, k); put_byte(8'h11, k); put_byte(8'h22, k); i2c_stop;
    w(2); check("R7 time writes", sqw_cnt - base, 2);
    base = sqw_cnt;
    wr_reg(8'd7, 8'h06); w(2); check("R7 other writes", sqw_cnt - base, 0);

    // R6 + R5 + R13 + R4: long read across wrap with live change
    tlive = 32'hA1B2C3D4;
    i2c_start; put_byte(AW, k); put_byte(8'd0, k);
    i2c_start; put_byte(AR, k);
    get_byte(1'b1, d); check("R6 byte0", d, 8'hD4);
    tlive = 32'h01020304;
    get_byte(1'b1, d); check("R6 byte1 from shadow", d, 8'hC3);
    get_byte(1'b1, d); check("R6 byte2 from shadow", d, 8'hB2);
    get_byte(1'b1, d); check("R6 byte3 from shadow", d, 8'hA1);
    get_byte(1'b1, d); check("R13 wdog byte0", d, 8'h44);
    get_byte(1'b1, d); check("R13 wdog byte1", d, 8'h55);
    get_byte(1'b1, d); check("R13 wdog byte2", d, 8'h66);
    get_byte(1'b1, d); check("R5 ctrl in sequence", d, 8'h06);
    get_byte(1'b1, d);
    get_byte(1'b1, d); check("R5 charger in sequence", d, 8'hB9);
    get_byte(1'b0, d); check("R5 R6 wrap to reg0 fresh copy", d, 8'h04);
    w(2); check("R4 released after nack", sda_oe, 1'b0);
    i2c_stop;

    // R3: read continues from stored pointer (now 1)
    i2c_start; put_byte(AR, k); get_byte(1'b0, d); i2c_stop;
    check("R3 continue pointer", d, 8'h03);

    // R12: out-of-range pointer selects register 0
    i2c_start; put_byte(AW, k); put_byte(8'h20, k); i2c_stop;
    i2c_start; put_byte(AR, k); get_byte(1'b0, d); i2c_stop;
    check("R12 pointer clamp", d, 8'h04);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule